// File: doc/BRIEF.md
# Dual-Compare Interval Timer with Capture and FSK Output

This block is an up-counter with two compare values that are used in turn, a toggle output, an interrupt pulse and a capture register fed by a synchronized, edge-selectable external input. Each compare value has its own four action bits, which decide what a match does: reset the counter, flip the output, pulse the interrupt, or halt the counter. Unequal periods on the two compares give a PWM waveform. A halt bit gives a one-shot pulse.

The operating mode picks how the counter is started and what the external input does. The input can have no effect, it can start an armed counter, it can copy the count into the capture register, or it can copy the count and then clear the counter. In the frequency-shift mode a serial data bit picks the active compare value. The output period then follows the data. Software programs the block through a small address/data port and starts it with a single control write. A clock-enable input sets the counting rate.

Top module: `dct_timer`

## Requirements
- R1: After reset the counter, capture register and status read 0, `tog_out` and `irq` are low, and the counter stays at 0 with `clk_en` high until a start is written.
- R2: Writing CTRL (address 0) with bit 5 set starts the block: the counter becomes 0 at that edge and the next match uses CMP1. If bit 6 is also set, `tog_out` flips at that edge. Writing CTRL with bit 5 clear stops the counter.
- R3: A match occurs on a rising clock edge where the counter is running, `clk_en` is high and the count equals the active compare value. Outside FSK mode the active compare alternates between CMP1 and CMP2 after every match, starting with CMP1.
- R4: MASK (address 3) holds bit 0 reset, bit 1 toggle, bit 2 interrupt and bit 3 halt for CMP1, and the same bits at 4 to 7 for CMP2. On a match the reset bit loads 0 instead of count+1, the toggle bit flips `tog_out`, and the interrupt bit drives `irq` high for the one cycle after the match edge.
- R5: A match whose halt bit is set stops the counter. The count then holds: it stays at the compare value, or at 0 if the reset bit is also set. It holds until the next start.
- R6: While `clk_en` is low the counter holds and no match occurs.
- R7: CTRL bits 4:3 select the input edges: 00 none, 01 rising, 10 falling, 11 both. A change on `ext_in` takes effect at the third rising clock edge after the change. Edges that are not selected have no effect.
- R8: Trigger mode (CTRL bits 2:0 = 1): after a start the counter stays at 0 until a selected edge. It counts from the tick after that edge.
- R9: Capture mode (mode 2): a selected edge loads the capture register (address 4) with the count as it stood at the acting clock edge. Counting continues.
- R10: Reset-capture mode (mode 3): a selected edge loads the capture register with the count and sets the counter to 0 at the same edge.
- R11: FSK mode (mode 4): `ser_bit` = 0 selects CMP1 and `ser_bit` = 1 selects CMP2 on every match, with no alternation. The mask bits of the selected compare apply. With reset and toggle set, the output half-period is compare value + 1 ticks.
- R12: STATUS (address 6) has bit 0 set when the last match was on CMP1, bit 1 set when it was on CMP2, and bit 2 set once a selected edge has been seen. A read with `rd_en` high clears all three bits at that edge. A new event on the same edge wins over the clear.
- R13: Addresses 1 and 2 hold CMP1 and CMP2, address 5 returns the live count, and reads of written registers return the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Count tick enable |
| ext_in | input | 1 | Asynchronous external event input |
| ser_bit | input | 1 | Serial data bit that selects the compare value in FSK mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears STATUS when reading it) |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` (combinational) |
| tog_out | output | 1 | Toggle output |
| irq | output | 1 | One-cycle interrupt pulse after a match |

## Verification
The bench sweeps every pair of compare values from 1 to 4 and compares each toggle and interrupt edge against an alternating schedule computed in the bench. A design that never advanced to CMP2, or advanced before the first match, would shift every later edge. The capture, reset-capture and trigger checks sample at the exact edge the two-stage synchronizer allows, so one stage too many or too few shows up as a capture value off by one. Falling-only and rising-only selections are driven with the opposite edge to catch a detector that ignores its select. FSK runs are checked for a constant period, which catches a design that keeps alternating in that mode. Single-action runs are checked for a counter that stays frozen at the compare value.

// File: rtl/dct_pkg.sv
// Shared encodings for the dual-compare timer: register addresses,
// operating modes and the per-compare action mask layout.
package dct_pkg;
    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_CMP1 = 3'd1;
    localparam logic [2:0] ADR_CMP2 = 3'd2;
    localparam logic [2:0] ADR_MASK = 3'd3;
    localparam logic [2:0] ADR_CAPT = 3'd4;
    localparam logic [2:0] ADR_CNT  = 3'd5;
    localparam logic [2:0] ADR_STAT = 3'd6;

    typedef enum logic [2:0] {
        MODE_FREE = 3'd0,
        MODE_TRIG = 3'd1,
        MODE_CAPT = 3'd2,
        MODE_RCAP = 3'd3,
        MODE_FSK  = 3'd4
    } mode_e;

    // One nibble of the MASK register, MSB first.
    typedef struct packed {
        logic halt;
        logic irq;
        logic tog;
        logic rst;
    } act_mask_t;
endpackage

// File: rtl/dct_edge.sv
// Edge detector for the external input.
// Assumes ext_in is asynchronous. It passes through SYNC_STAGES flops and
// one history flop, so the selected edge reaches the core on the third
// rising edge after the change (with the default of two stages).
module dct_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_in,
    input  logic [1:0] sel,
    output logic       edge_hit
);
    logic [SYNC_STAGES:0] chain;

    // Shift the input through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], ext_in};
    end

    // Compare the newest synchronized sample with the one before it.
    always_comb begin
        edge_hit = (sel[0] &  chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES])
                 | (sel[1] & ~chain[SYNC_STAGES-1] &  chain[SYNC_STAGES]);
    end
endmodule

// File: rtl/dct_regs.sv
// Register port for the dual-compare timer.
// Holds control, compare and mask registers and decodes the start/stop
// strobes. On a CTRL write the mode, edge select and start-toggle fields
// are passed straight from wdata, so the core acts on the new values at
// the same edge. Assumes W >= 8.
module dct_regs
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] capt,
    input  logic [W-1:0] cnt,
    input  logic [2:0]   status,
    output mode_e        mode,
    output logic [1:0]   edge_sel,
    output logic         tas,
    output logic [W-1:0] cmp1,
    output logic [W-1:0] cmp2,
    output act_mask_t    mask1,
    output act_mask_t    mask2,
    output logic         start_p,
    output logic         stop_p,
    output logic         stat_clr
);
    logic [7:0] ctrl_q;
    logic [7:0] mask_q;
    logic       ctrl_wr;

    assign ctrl_wr  = wr_en && (addr == ADR_CTRL);
    assign start_p  = ctrl_wr &&  wdata[5];
    assign stop_p   = ctrl_wr && !wdata[5];
    assign stat_clr = rd_en && (addr == ADR_STAT);

    // Store the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            cmp1   <= '0;
            cmp2   <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: ctrl_q <= wdata[7:0];
                ADR_CMP1: cmp1   <= wdata;
                ADR_CMP2: cmp2   <= wdata;
                ADR_MASK: mask_q <= wdata[7:0];
                default:  ;
            endcase
        end
    end

    // Use the write data during a CTRL write, the stored fields otherwise.
    always_comb begin
        logic [7:0] c;
        c        = ctrl_wr ? wdata[7:0] : ctrl_q;
        mode     = mode_e'(c[2:0]);
        edge_sel = c[4:3];
        tas      = c[6];
        mask1    = act_mask_t'(mask_q[3:0]);
        mask2    = act_mask_t'(mask_q[7:4]);
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADR_CTRL: rdata = W'(ctrl_q);
            ADR_CMP1: rdata = cmp1;
            ADR_CMP2: rdata = cmp2;
            ADR_MASK: rdata = W'(mask_q);
            ADR_CAPT: rdata = capt;
            ADR_CNT:  rdata = cnt;
            ADR_STAT: rdata = W'(status);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dct_core.sv
// Counter core of the dual-compare timer.
// Selects the active compare value (alternating, or from ser_bit in FSK
// mode), applies that compare's action mask on a match, and handles the
// trigger, capture and reset-capture uses of the edge input.
// Assumes start_p and stop_p are never high together.
module dct_core
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         ser_bit,
    input  logic         edge_hit,
    input  mode_e        mode,
    input  logic         tas,
    input  logic [W-1:0] cmp1,
    input  logic [W-1:0] cmp2,
    input  act_mask_t    mask1,
    input  act_mask_t    mask2,
    input  logic         start_p,
    input  logic         stop_p,
    input  logic         stat_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] capt,
    output logic [2:0]   status,
    output logic         tog_out,
    output logic         irq
);
    logic       running;
    logic       armed;
    logic       use2_ptr;
    logic       use2;
    logic [W-1:0] cmp_act;
    act_mask_t  act;
    logic       hit_q;
    logic       cap_evt;
    logic       rcap_evt;
    logic [1:0] last_hit;
    logic       edge_seen;

    // Pick the active compare value and its action mask.
    always_comb begin
        use2    = (mode == MODE_FSK) ? ser_bit : use2_ptr;
        cmp_act = use2 ? cmp2 : cmp1;
        act     = use2 ? mask2 : mask1;
        hit_q   = running && clk_en && (cnt == cmp_act) && !start_p;
        cap_evt = edge_hit && ((mode == MODE_CAPT) || (mode == MODE_RCAP));
        rcap_evt = edge_hit && (mode == MODE_RCAP);
    end

    // Counter value with start, reset-capture and match priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (start_p)          cnt <= '0;
        else if (rcap_evt)         cnt <= '0;
        else if (hit_q && act.rst) cnt <= '0;
        else if (hit_q && act.halt) cnt <= cnt;
        else if (running && clk_en) cnt <= cnt + 1'b1;
    end

    // Run and trigger-arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            armed   <= 1'b0;
        end else if (start_p) begin
            running <= (mode != MODE_TRIG);
            armed   <= (mode == MODE_TRIG);
        end else if (stop_p) begin
            running <= 1'b0;
            armed   <= 1'b0;
        end else if (armed && edge_hit) begin
            running <= 1'b1;
            armed   <= 1'b0;
        end else if (hit_q && act.halt) begin
            running <= 1'b0;
        end
    end

    // Alternation pointer: cleared by start, flipped by each non-FSK match.
    always_ff @(posedge clk) begin
        if (!rst_n || start_p)                use2_ptr <= 1'b0;
        else if (hit_q && mode != MODE_FSK)   use2_ptr <= ~use2_ptr;
    end

    // Output toggle flip-flop and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_out <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (start_p ? tas : (hit_q && act.tog)) tog_out <= ~tog_out;
            irq <= hit_q && act.irq;
        end
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)       capt <= '0;
        else if (cap_evt) capt <= cnt;
    end

    // Status flags: set by events, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_hit  <= 2'b00;
            edge_seen <= 1'b0;
        end else begin
            if (hit_q)         last_hit <= {use2, ~use2};
            else if (stat_clr) last_hit <= 2'b00;
            if (edge_hit)      edge_seen <= 1'b1;
            else if (stat_clr) edge_seen <= 1'b0;
        end
    end

    assign status = {edge_seen, last_hit};

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (cnt == '0));                                       // R2
    AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && act.rst) |=> (cnt == '0));                            // R4
    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && act.halt) |=> !running);                              // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !start_p && !rcap_evt) |=> $stable(cnt));           // R6
    AST_ARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt == '0));                                         // R8
    AST_LAST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(last_hit));                                            // R12
endmodule

// File: rtl/dct_timer.sv
// Dual-compare interval timer with capture and FSK output: top level.
// Connects the edge detector, the register port and the counter core.
// Assumes a single clock domain apart from ext_in, and W >= 8.
module dct_timer
    import dct_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         ext_in,
    input  logic         ser_bit,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         tog_out,
    output logic         irq
);
    mode_e        mode;
    logic [1:0]   edge_sel;
    logic         tas;
    logic [W-1:0] cmp1, cmp2, cnt, capt;
    act_mask_t    mask1, mask2;
    logic         start_p, stop_p, stat_clr, edge_hit;
    logic [2:0]   status;

    dct_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .sel(edge_sel),
        .edge_hit(edge_hit)
    );

    dct_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .capt(capt), .cnt(cnt),
        .status(status), .mode(mode), .edge_sel(edge_sel), .tas(tas),
        .cmp1(cmp1), .cmp2(cmp2), .mask1(mask1), .mask2(mask2),
        .start_p(start_p), .stop_p(stop_p), .stat_clr(stat_clr)
    );

    dct_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ser_bit(ser_bit),
        .edge_hit(edge_hit), .mode(mode), .tas(tas), .cmp1(cmp1),
        .cmp2(cmp2), .mask1(mask1), .mask2(mask2), .start_p(start_p),
        .stop_p(stop_p), .stat_clr(stat_clr), .cnt(cnt), .capt(capt),
        .status(status), .tog_out(tog_out), .irq(irq)
    );
endmodule

// File: tb/sim_dct_timer.sv
`timescale 1ns/1ps
module sim_dct_timer;
    localparam int W = 8;
    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, ext_in = 1'b0, ser_bit = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [W-1:0] wdata = '0, rdata;
    logic tog_out, irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dct_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ext_in(ext_in),
        .ser_bit(ser_bit), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tog_out(tog_out), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        addr = a; #1; v = int'(rdata);
    endtask

    task automatic rd_clr(input logic [2:0] a, output int v);
        addr = a; rd_en = 1'b1; #1; v = int'(rdata);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Count toggle-edge positions that differ from a fixed period.
    task automatic fsk_run(input bit sb, input int per, input string req);
        int bad = 0;
        logic prev;
        ser_bit = sb;
        wr(3'd0, 8'h24);
        prev = tog_out;
        for (int e = 1; e <= 30; e++) begin
            @(negedge clk);
            if ((tog_out != prev) != (e % per == 0)) bad++;
            prev = tog_out;
        end
        chk(bad == 0, req, bad, 0);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        int v;
        logic t0;
        waitn(3);
        rst_n = 1'b1;
        // R1: reset state and no counting before a start
        peek(3'd5, v); chk(v == 0, "R1 count", v, 0);
        peek(3'd6, v); chk(v == 0, "R1 status", v, 0);
        peek(3'd4, v); chk(v == 0, "R1 capture", v, 0);
        chk(tog_out == 0 && irq == 0, "R1 outputs", int'({tog_out, irq}), 0);
        clk_en = 1'b1;
        waitn(5);
        peek(3'd5, v); chk(v == 0, "R1 idle count", v, 0);

        // R13: register readback
        wr(3'd1, 8'hA5); peek(3'd1, v); chk(v == 8'hA5, "R13 cmp1", v, 8'hA5);
        wr(3'd3, 8'h73); peek(3'd3, v); chk(v == 8'h73, "R13 mask", v, 8'h73);

        // R3/R4: sweep of compare pairs with alternating schedule
        for (int c1 = 1; c1 <= 4; c1++) begin
            for (int c2 = 1; c2 <= 4; c2++) begin
                int bad_t = 0, bad_i = 0, nm, which;
                logic prev;
                wr(3'd1, W'(c1)); wr(3'd2, W'(c2));
                wr(3'd0, 8'h20);
                prev = tog_out; nm = c1 + 1; which = 0;
                for (int e = 1; e <= 40; e++) begin
                    bit m;
                    @(negedge clk);
                    m = (e == nm);
                    if ((tog_out != prev) != m) bad_t++;
                    if (irq != (m && which == 1)) bad_i++;
                    prev = tog_out;
                    if (m) begin
                        nm = nm + ((which == 0) ? c2 : c1) + 1;
                        which ^= 1;
                    end
                end
                chk(bad_t == 0, $sformatf("R3 toggle schedule c1=%0d c2=%0d", c1, c2), bad_t, 0);
                chk(bad_i == 0, $sformatf("R4 irq on cmp2 only c1=%0d c2=%0d", c1, c2), bad_i, 0);
                wr(3'd0, 8'h00);
            end
        end

        // R2: start with toggle-at-start
        t0 = tog_out;
        wr(3'd0, 8'h60);
        chk(tog_out == ~t0, "R2 toggle at start", int'(tog_out), int'(~t0));
        wr(3'd0, 8'h00);

        // R12: status flags, clear on read
        wr(3'd1, 8'd2); wr(3'd2, 8'd9); wr(3'd3, 8'h11);
        wr(3'd0, 8'h20);
        waitn(5);
        peek(3'd6, v); chk(v == 1, "R12 cmp1 last", v, 1);
        rd_clr(3'd6, v);
        peek(3'd6, v); chk(v == 0, "R12 cleared by read", v, 0);
        waitn(8);
        peek(3'd6, v); chk(v == 2, "R12 cmp2 last", v, 2);
        wr(3'd0, 8'h00);

        // R5: halt on match; R2: restart clears counter
        wr(3'd1, 8'd5); wr(3'd3, 8'h0A);
        wr(3'd0, 8'h20);
        t0 = tog_out;
        waitn(20);
        peek(3'd5, v); chk(v == 5, "R5 count frozen", v, 5);
        chk(tog_out == ~t0, "R5 single toggle", int'(tog_out), int'(~t0));
        wr(3'd0, 8'h20);
        peek(3'd5, v); chk(v == 0, "R2 start clears count", v, 0);
        wr(3'd0, 8'h00);

        // R6: clock enable low holds the counter
        wr(3'd1, 8'd200); wr(3'd2, 8'd200); wr(3'd3, 8'h00);
        wr(3'd0, 8'h20);
        waitn(10);
        peek(3'd5, v); chk(v == 10, "R6 count before", v, 10);
        clk_en = 1'b0; waitn(7);
        peek(3'd5, v); chk(v == 10, "R6 count held", v, 10);
        clk_en = 1'b1; waitn(3);
        peek(3'd5, v); chk(v == 13, "R6 count resumed", v, 13);

        // R9/R7: capture on rising edge, three-edge latency
        wr(3'd0, 8'h2A);
        waitn(10); ext_in = 1'b1;
        waitn(2);
        peek(3'd4, v); chk(v == 0, "R7 no early capture", v, 0);
        waitn(1);
        peek(3'd4, v); chk(v == 12, "R9 capture value", v, 12);
        peek(3'd5, v); chk(v == 13, "R9 counting continues", v, 13);
        peek(3'd6, v); chk(v[2] == 1'b1, "R12 edge flag", v, 4);
        waitn(7); ext_in = 1'b0; waitn(5);
        peek(3'd4, v); chk(v == 12, "R7 falling ignored when rising selected", v, 12);
        // R7: both edges
        wr(3'd0, 8'h3A);
        waitn(4); ext_in = 1'b1; waitn(3);
        peek(3'd4, v); chk(v == 6, "R7 both: rising", v, 6);
        waitn(2); ext_in = 1'b0; waitn(3);
        peek(3'd4, v); chk(v == 11, "R7 both: falling", v, 11);
        // R7: falling only
        wr(3'd0, 8'h32);
        waitn(4); ext_in = 1'b1; waitn(2); ext_in = 1'b0; waitn(2);
        peek(3'd4, v); chk(v == 11, "R7 rising ignored when falling selected", v, 11);
        waitn(1);
        peek(3'd4, v); chk(v == 8, "R7 falling capture", v, 8);

        // R10: reset-capture
        wr(3'd0, 8'h2B);
        waitn(10); ext_in = 1'b1; waitn(3);
        peek(3'd4, v); chk(v == 12, "R10 capture value", v, 12);
        peek(3'd5, v); chk(v == 0, "R10 counter reset", v, 0);
        waitn(1);
        peek(3'd5, v); chk(v == 1, "R10 count after reset", v, 1);
        ext_in = 1'b0; waitn(4);

        // R8: trigger start
        wr(3'd0, 8'h29);
        waitn(6);
        peek(3'd5, v); chk(v == 0, "R8 idle before edge", v, 0);
        ext_in = 1'b1; waitn(3);
        peek(3'd5, v); chk(v == 0, "R8 zero at trigger edge", v, 0);
        waitn(1);
        peek(3'd5, v); chk(v == 1, "R8 first tick", v, 1);
        waitn(2);
        peek(3'd5, v); chk(v == 3, "R8 counting", v, 3);
        wr(3'd0, 8'h00);

        // R11: FSK period follows ser_bit
        wr(3'd1, 8'd3); wr(3'd2, 8'd5); wr(3'd3, 8'h33);
        fsk_run(1'b0, 4, "R11 ser_bit=0 uses CMP1");
        fsk_run(1'b1, 6, "R11 ser_bit=1 uses CMP2");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule